// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between one core's load/store request port and a shared memory port and enforces total-store-order rules. A store is taken in a single handshake and the core carries on at once. The store waits in an in-order queue and is written to memory later, oldest first, whenever the memory port has room. A load first searches the queue. If one or more queued stores target its address, the newest of them supplies the data. Otherwise the load goes to memory, and it may get there ahead of older queued stores to other addresses.

A fence request is answered only after every queued store has reached memory. An atomic swap also waits for the queue to empty. It then reads the old word at memory, writes the new word to the same address and returns the old word, so it orders like a fence. The core has one non-store request in flight at a time. Responses come back as a one-cycle pulse. The memory port uses a valid/ready handshake, and read data returns on a separate valid strobe.

Top module: `tso_store_buffer`

## Requirements
- R1: Queued stores reach the memory port as write requests in exactly the order the core issued them, each with its own address and data.
- R2: While the controller is idle and fewer than DEPTH stores are queued, a store (req_op 2'b01) is accepted in the cycle it is presented. It gets no response pulse, and buf_empty is low in the cycle after acceptance.
- R3: A queued store makes no change to memory until its drain write is accepted. While mem_req_ready stays low, no transaction completes.
- R4: A load (req_op 2'b00) whose address matches queued stores returns, one cycle after acceptance, the data of the most recently queued matching store, without a memory transaction.
- R5: A load with no matching queued store reads memory and returns the memory word on rsp_rdata.
- R6: A fence (req_op 2'b10) is answered with rsp_valid only once the queue is empty, and at that point every earlier store is in memory.
- R7: An atomic swap (req_op 2'b11) drains the queue, then reads and writes its address at memory with the queue empty, and returns the old word. Memory then holds the new word.
- R8: A load miss issued while stores are queued waits for at most the one drain write already holding the port. Its read then goes ahead of the remaining older stores.
- R9: When DEPTH stores are queued, req_ready is low for a store but stays high for a load.
- R10: A memory request held with mem_req_ready low keeps valid, write flag, address and data unchanged until it is accepted.
- R11: After reset, buf_empty is high, rsp_valid and mem_req_valid are low, and req_ready is high. A drain write is never issued with the queue empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted when valid is also high |
| req_op | input | 2 | 00 load, 01 store, 10 fence, 11 atomic swap |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Store or swap data |
| rsp_valid | output | 1 | One-cycle response pulse for load, fence and swap |
| rsp_rdata | output | DATA_W | Load data or old word of a swap |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| buf_empty | output | 1 | No store is queued |

## Verification
The hardest case to reach is a load miss that overtakes older stores. It needs several stores queued, a drain write stalled on the port, and a miss presented behind them. The bench holds mem_req_ready low to build up the queue, shows that memory and the transaction log are unchanged, then issues the miss and releases the port. It then checks the exact order of write, read, write, write. Random traffic with a randomly toggling ready drives stalls, forwarding hits on a small address range, and fences and swaps that arrive while stores are queued.

// File: rtl/sb_pkg.sv
// Shared types for the ordered store queue.
// Assumes a single core-side requester with one non-store request in flight.
package sb_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10,
        OP_SWAP  = 2'b11
    } sb_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LD_RD,
        S_LD_WAIT,
        S_FENCE,
        S_SW_DRAIN,
        S_SW_RD,
        S_SW_WAIT,
        S_SW_WR
    } sb_state_e;
endpackage

// File: rtl/sb_fifo.sv
// Circular queue of pending stores. Every slot is exposed for the forwarding
// search. Assumes DEPTH is a power of two, at least 2. Push when full and pop
// when empty are ignored.
module sb_fifo #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] slot_addr [DEPTH],
    output logic [DATA_W-1:0] slot_data [DEPTH],
    output logic [PTR_W-1:0]  head_ptr,
    output logic [CNT_W-1:0]  occ,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data
);
    logic [PTR_W-1:0] tail_q;
    logic [PTR_W-1:0] head_q;
    logic [CNT_W-1:0] occ_q;
    logic             do_push;
    logic             do_pop;

    // Qualify push and pop against occupancy.
    always_comb begin
        do_push = push && (occ_q != CNT_W'(DEPTH));
        do_pop  = pop && (occ_q != '0);
    end

    // Write the incoming store into the tail slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_addr[i] <= '0;
                slot_data[i] <= '0;
            end
        end else if (do_push) begin
            slot_addr[tail_q] <= push_addr;
            slot_data[tail_q] <= push_data;
        end
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (do_push) tail_q <= tail_q + 1'b1;
            if (do_pop)  head_q <= head_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // Status and the oldest entry.
    always_comb begin
        head_ptr  = head_q;
        occ       = occ_q;
        full      = (occ_q == CNT_W'(DEPTH));
        empty     = (occ_q == '0);
        head_addr = slot_addr[head_q];
        head_data = slot_data[head_q];
    end
endmodule

// File: rtl/sb_fwd.sv
// Address match over the live queue slots. The newest match supplies the data.
// Slots are scanned by age, counted from the head, so later (younger) hits win.
module sb_fwd #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [DATA_W-1:0] slot_data [DEPTH],
    input  logic [PTR_W-1:0]  head_ptr,
    input  logic [CNT_W-1:0]  occ,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [DATA_W-1:0] fwd_data
);
    logic [DEPTH-1:0]  age_match;
    logic [DATA_W-1:0] age_data [DEPTH];

    // One comparator per age position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PTR_W-1:0] idx;
        assign idx          = head_ptr + PTR_W'(g);
        assign age_match[g] = (CNT_W'(g) < occ) && (slot_addr[idx] == look_addr);
        assign age_data[g]  = slot_data[idx];
    end

    // Priority select: the youngest matching age wins.
    always_comb begin
        hit      = 1'b0;
        fwd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_match[k]) begin
                hit      = 1'b1;
                fwd_data = age_data[k];
            end
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
// Request sequencer: it accepts core requests, answers forwarded loads, and runs
// load misses, fences and atomic swaps. Assumes the memory read response arrives
// after its request is accepted, and that ctrl_mem_ready is only high while
// this module owns the memory port.
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              buf_full,
    input  logic              buf_empty,
    input  logic              fwd_hit,
    input  logic [DATA_W-1:0] fwd_data,
    output logic              push,
    output logic              ctrl_mem_valid,
    output logic              ctrl_mem_we,
    output logic [ADDR_W-1:0] ctrl_mem_addr,
    output logic [DATA_W-1:0] ctrl_mem_wdata,
    input  logic              ctrl_mem_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    sb_state_e         state_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;
    logic              accept;
    sb_op_e            op;

    // Core handshake: only idle accepts, and stores also need a free slot.
    always_comb begin
        op        = sb_op_e'(req_op);
        req_ready = (state_q == S_IDLE) && !((op == OP_STORE) && buf_full);
        accept    = req_valid && req_ready;
        push      = accept && (op == OP_STORE);
    end

    // Memory request driven by the sequencer for misses and swaps.
    always_comb begin
        ctrl_mem_valid = (state_q == S_LD_RD) || (state_q == S_SW_RD) ||
                         (state_q == S_SW_WR);
        ctrl_mem_we    = (state_q == S_SW_WR);
        ctrl_mem_addr  = op_addr_q;
        ctrl_mem_wdata = op_wdata_q;
    end

    // Sequencer state, request capture and the response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        op_addr_q  <= req_addr;
                        op_wdata_q <= req_wdata;
                        case (op)
                            OP_LOAD: begin
                                if (fwd_hit) begin
                                    rsp_valid <= 1'b1;
                                    rsp_rdata <= fwd_data;
                                end else begin
                                    state_q <= S_LD_RD;
                                end
                            end
                            OP_FENCE: state_q <= S_FENCE;
                            OP_SWAP:  state_q <= S_SW_DRAIN;
                            default:  state_q <= S_IDLE;
                        endcase
                    end
                end
                S_LD_RD: if (ctrl_mem_ready) state_q <= S_LD_WAIT;
                S_LD_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mem_rsp_rdata;
                        state_q   <= S_IDLE;
                    end
                end
                S_FENCE: begin
                    if (buf_empty) begin
                        rsp_valid <= 1'b1;
                        state_q   <= S_IDLE;
                    end
                end
                S_SW_DRAIN: if (buf_empty) state_q <= S_SW_RD;
                S_SW_RD: if (ctrl_mem_ready) state_q <= S_SW_WAIT;
                S_SW_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_rdata <= mem_rsp_rdata;
                        state_q   <= S_SW_WR;
                    end
                end
                S_SW_WR: begin
                    if (ctrl_mem_ready) begin
                        rsp_valid <= 1'b1;
                        state_q   <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tso_store_buffer.sv
// Top of the ordered store queue. It joins queue, forwarding search and sequencer,
// and shares the memory port between drain writes and sequencer requests.
// Assumes the memory side obeys valid/ready and returns read data with
// mem_rsp_valid in a later cycle.
module tso_store_buffer #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              buf_empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [PTR_W-1:0]  head_ptr;
    logic [CNT_W-1:0]  occ;
    logic              q_full;
    logic              q_empty;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              push;
    logic              pop;
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_data;
    logic              ctrl_mem_valid;
    logic              ctrl_mem_we;
    logic [ADDR_W-1:0] ctrl_mem_addr;
    logic [DATA_W-1:0] ctrl_mem_wdata;
    logic              ctrl_mem_ready;
    logic              ctrl_grant;
    logic              drain_valid;
    logic              drain_hold_q;

    sb_fifo #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(req_addr), .push_data(req_wdata),
        .pop(pop),
        .slot_addr(slot_addr), .slot_data(slot_data),
        .head_ptr(head_ptr), .occ(occ),
        .full(q_full), .empty(q_empty),
        .head_addr(head_addr), .head_data(head_data)
    );

    sb_fwd #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_fwd (
        .slot_addr(slot_addr), .slot_data(slot_data),
        .head_ptr(head_ptr), .occ(occ),
        .look_addr(req_addr),
        .hit(fwd_hit), .fwd_data(fwd_data)
    );

    sb_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .buf_full(q_full), .buf_empty(q_empty),
        .fwd_hit(fwd_hit), .fwd_data(fwd_data),
        .push(push),
        .ctrl_mem_valid(ctrl_mem_valid), .ctrl_mem_we(ctrl_mem_we),
        .ctrl_mem_addr(ctrl_mem_addr), .ctrl_mem_wdata(ctrl_mem_wdata),
        .ctrl_mem_ready(ctrl_mem_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Port arbitration: a stalled drain keeps the port, otherwise the sequencer wins.
    always_comb begin
        ctrl_grant     = ctrl_mem_valid && !drain_hold_q;
        drain_valid    = !q_empty && (drain_hold_q || !ctrl_mem_valid);
        mem_req_valid  = drain_valid || ctrl_grant;
        mem_req_we     = drain_valid ? 1'b1 : ctrl_mem_we;
        mem_req_addr   = drain_valid ? head_addr : ctrl_mem_addr;
        mem_req_wdata  = drain_valid ? head_data : ctrl_mem_wdata;
        pop            = drain_valid && mem_req_ready;
        ctrl_mem_ready = ctrl_grant && mem_req_ready;
        buf_empty      = q_empty;
    end

    // Remember a drain write that was presented but not yet accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) drain_hold_q <= 1'b0;
        else        drain_hold_q <= drain_valid && !mem_req_ready;
    end
endmodule

// File: rtl/sb_checker.sv
// Protocol and ordering properties of the store queue, bound into its top.
// Tracks the last accepted request kind to decide which rule applies.
module sb_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [1:0]                 req_op,
    input logic                       rsp_valid,
    input logic                       mem_req_valid,
    input logic                       mem_req_ready,
    input logic                       mem_req_we,
    input logic [ADDR_W-1:0]          mem_req_addr,
    input logic [DATA_W-1:0]          mem_req_wdata,
    input logic                       buf_empty,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    logic [1:0] last_op;

    // Record the kind of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_op <= 2'b00;
        else if (req_valid && req_ready) last_op <= req_op;
    end

    p_fence_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_op == 2'b10) |-> buf_empty);

    p_swap_read_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == 2'b11 && mem_req_valid && !mem_req_we) |-> buf_empty);

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) &&
             $stable(mem_req_wdata)));

    p_full_blocks_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == ($clog2(DEPTH+1))'(DEPTH)) |-> !(req_ready && req_op == 2'b01));

    p_no_empty_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && last_op != 2'b11) |-> !(mem_req_valid && mem_req_we));
endmodule

bind tso_store_buffer sb_checker #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sb_checker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .rsp_valid(rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .buf_empty(buf_empty), .occ(occ)
);

// File: tb/tb_tso_store_buffer.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// against a reference model of pending stores and a memory model.
module tb_tso_store_buffer;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_rdata = '0;
    logic              buf_empty;

    always #5 clk = ~clk;

    tso_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .buf_empty(buf_empty)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int rdy_mode = 0;          // 0 always ready, 1 random, 2 held low
    int last_wait = 0;
    logic [DATA_W-1:0] mem [256];
    logic [ADDR_W-1:0] pa [64];
    logic [DATA_W-1:0] pd [64];
    int ptot = 0;              // stores pushed (bench side)
    int pdone = 0;             // stores seen written to memory
    logic [ADDR_W-1:0] sw_addr = '0;
    logic [DATA_W-1:0] sw_wdata = '0;
    logic              tlog_we [4096];
    logic [ADDR_W-1:0] tlog_addr [4096];
    int tcount = 0;
    logic              prev_stall = 1'b0;
    logic              prev_we = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [DATA_W-1:0] prev_wdata = '0;

    function automatic logic [DATA_W-1:0] init_val(input int i);
        return 32'h1000_0000 + 32'(i) * 32'd3;
    endfunction

    // Expected load value: youngest pending store to the address, else memory.
    function automatic logic [DATA_W-1:0] exp_load(input logic [ADDR_W-1:0] a);
        for (int i = ptot - 1; i >= pdone; i--)
            if (pa[i % 64] == a) return pd[i % 64];
        return mem[a];
    endfunction

    function automatic bit pending_has(input logic [ADDR_W-1:0] a);
        for (int i = ptot - 1; i >= pdone; i--)
            if (pa[i % 64] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Memory model: applies writes, returns reads one cycle later, checks order.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            mem_rsp_valid <= 1'b0;
            prev_stall    <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (prev_stall)   // R10: held request must not change
                chk(mem_req_valid && mem_req_we == prev_we && mem_req_addr == prev_addr &&
                    mem_req_wdata == prev_wdata, "R10", mem_req_wdata, prev_wdata);
            if (mem_req_valid && mem_req_ready) begin
                tlog_we[tcount % 4096]   = mem_req_we;
                tlog_addr[tcount % 4096] = mem_req_addr;
                tcount++;
                if (mem_req_we) begin
                    if (ptot > pdone) begin   // R1: drain order
                        chk(mem_req_addr == pa[pdone % 64] && mem_req_wdata == pd[pdone % 64],
                            "R1", mem_req_wdata, pd[pdone % 64]);
                        pdone++;
                    end else begin            // R7: swap write
                        chk(mem_req_addr == sw_addr && mem_req_wdata == sw_wdata,
                            "R7", mem_req_wdata, sw_wdata);
                    end
                    mem[mem_req_addr] <= mem_req_wdata;
                end else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem[mem_req_addr];
                end
            end
            prev_stall <= mem_req_valid && !mem_req_ready;
            prev_we    <= mem_req_we;
            prev_addr  <= mem_req_addr;
            prev_wdata <= mem_req_wdata;
        end
        case (rdy_mode)
            0:       mem_req_ready <= 1'b1;
            1:       mem_req_ready <= 1'($urandom % 2);
            default: mem_req_ready <= 1'b0;
        endcase
    end

    // One core request; waits for acceptance and for the response if any.
    task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input string tag);
        logic [DATA_W-1:0] expv;
        int t;
        bit go;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        t = 0; go = 1'b0;
        while (!go) begin
            #1;
            if (req_ready) go = 1'b1;
            else begin
                @(negedge clk);
                t++;
                if (t > 2000) begin
                    chk(1'b0, {tag, " accept timeout"}, 32'(t), 32'd0);
                    req_valid = 1'b0;
                    return;
                end
            end
        end
        last_wait = t;
        expv = exp_load(a);
        if (op == 2'b01) begin
            pa[ptot % 64] = a; pd[ptot % 64] = d; ptot++;
        end
        if (op == 2'b11) begin
            sw_addr = a; sw_wdata = d;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 2'b01) return;
        t = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            t++;
            if (t > 2000) begin
                chk(1'b0, {tag, " response timeout"}, 32'(t), 32'd0);
                return;
            end
        end
        case (op)
            2'b00: chk(rsp_rdata == expv, tag, rsp_rdata, expv);
            2'b10: chk(buf_empty && ptot == pdone, "R6", 32'(ptot - pdone), 32'd0);
            default: begin
                chk(rsp_rdata == expv, "R7 old word", rsp_rdata, expv);
                @(negedge clk);
                chk(mem[a] == d, "R7 new word", mem[a], d);
            end
        endcase
    endtask

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int mark;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: reset state
        chk(buf_empty == 1'b1, "R11 empty", 32'(buf_empty), 32'd1);
        chk(rsp_valid == 1'b0, "R11 rsp", 32'(rsp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R11 mem", 32'(mem_req_valid), 32'd0);
        chk(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);

        // R5: load miss reads memory
        do_op(2'b00, 8'd3, '0, "R5");

        // R2, R3, R4: stores queue while memory is stalled
        rdy_mode = 2;
        repeat (2) @(negedge clk);
        mark = tcount;
        do_op(2'b01, 8'd3, 32'd5, "R2");
        chk(last_wait == 0, "R2 accept", 32'(last_wait), 32'd0);
        do_op(2'b01, 8'd3, 32'd6, "R2");
        do_op(2'b01, 8'd3, 32'd7, "R2");
        chk(last_wait == 0, "R2 accept", 32'(last_wait), 32'd0);
        chk(buf_empty == 1'b0, "R2 queued", 32'(buf_empty), 32'd0);
        do_op(2'b00, 8'd3, '0, "R4 youngest");
        chk(tcount == mark, "R3 no transaction", 32'(tcount), 32'(mark));

        // R8: load miss overtakes the older queued stores
        fork
            do_op(2'b00, 8'd9, '0, "R8 data");
            begin
                repeat (6) @(negedge clk);
                chk(mem[3] == init_val(3), "R3 memory untouched", mem[3], init_val(3));
                rdy_mode = 0;
            end
        join
        do_op(2'b10, '0, '0, "R6");
        chk(tlog_we[mark % 4096] == 1'b1, "R8 first is drain", 32'(tlog_we[mark % 4096]), 32'd1);
        chk(tlog_we[(mark + 1) % 4096] == 1'b0 && tlog_addr[(mark + 1) % 4096] == 8'd9,
            "R8 read second", 32'(tlog_addr[(mark + 1) % 4096]), 32'd9);
        chk(tlog_we[(mark + 2) % 4096] == 1'b1 && tlog_we[(mark + 3) % 4096] == 1'b1,
            "R8 rest drain after", 32'(tlog_we[(mark + 2) % 4096]), 32'd1);
        chk(mem[3] == 32'd7, "R1 final value", mem[3], 32'd7);

        // R9: full queue stalls stores only
        rdy_mode = 2;
        repeat (2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) do_op(2'b01, 8'(20 + i), 32'(100 + i), "R9 fill");
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = 8'd30; req_wdata = 32'd1;
        #1;
        chk(req_ready == 1'b0, "R9 store stalls", 32'(req_ready), 32'd0);
        req_op = 2'b00;
        #1;
        chk(req_ready == 1'b1, "R9 load accepted", 32'(req_ready), 32'd1);
        req_valid = 1'b0;
        rdy_mode = 0;
        do_op(2'b10, '0, '0, "R6");

        // R7: swap with a queued store to the same address
        rdy_mode = 1;
        do_op(2'b01, 8'd40, 32'hAAAA_0001, "R2");
        do_op(2'b01, 8'd41, 32'hAAAA_0002, "R2");
        do_op(2'b11, 8'd40, 32'hBBBB_0003, "R7");

        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            int r;
            logic [ADDR_W-1:0] a;
            r = int'($urandom % 10);
            a = ADDR_W'($urandom % 16);
            if (r < 4)      do_op(2'b00, a, '0, pending_has(a) ? "R4" : "R5");
            else if (r < 8) do_op(2'b01, a, $urandom, "R2");
            else if (r < 9) do_op(2'b10, '0, '0, "R6");
            else            do_op(2'b11, a, $urandom, "R7");
        end
        rdy_mode = 0;
        do_op(2'b10, '0, '0, "R6");
        chk(ptot == pdone, "R1 all drained", 32'(pdone), 32'(ptot));
        finish_run();
    end
endmodule